// File: doc/BRIEF.md
# SIMT Divergence Stack Controller

This block holds the divergence stack of one wavefront in a SIMT core. Every entry carries three fields: a program counter, a reconvergence program counter (the address where the diverged lanes meet again) and a per-lane execution mask. Only the top entry is visible. It supplies the current pc, the reconvergence pc, the active lane mask and a count of the active lanes. Branch logic pushes a new entry when lanes diverge. Taken control flow overwrites the top pc through a write port. A retire strobe marks each instruction that finished without changing the pc.

On a plain retire the top pc advances by one, and the advanced value is compared with the top entry's reconvergence pc. If they differ, the head of the instruction buffer is dequeued. If they match, the entry is popped and the instruction buffer is flushed. The flush asks for a pending fetch to be discarded on its return. Illegal requests are refused and reported on one-cycle error pulses. These are: pushing a mask with no lanes, pushing onto a full stack, and retiring or writing the pc with no entry present.

All effects appear at the outputs right after the clock edge that samples the request. Every pulse output lasts exactly one cycle.

Top module: `simt_divergence_stack`

## Requirements
- R1: After reset the stack holds no entries: cur_pc, cur_rpc, cur_mask and active_lanes read zero and every pulse output is low. The same zero outputs appear whenever the stack becomes empty again.
- R2: A push with a nonzero mask onto a stack holding fewer than DEPTH entries becomes the new top. After the edge, cur_pc, cur_rpc and cur_mask show the pushed values.
- R3: A push whose mask is all zero raises err_empty_push for one cycle and leaves the stack and all current outputs unchanged.
- R4: A push with a nonzero mask onto a stack holding DEPTH entries raises err_overflow for one cycle and leaves the stack unchanged.
- R5: A retire without a pc write sets the top pc to pc+1, wrapping modulo 2^PC_W. If that value differs from the top reconvergence pc, head_dequeue pulses for one cycle.
- R6: If the advanced pc equals the top reconvergence pc, the top entry is popped and buf_flush pulses for one cycle; head_dequeue stays low. The entry below becomes the top with its own stored pc, reconvergence pc and mask.
- R7: drop_fetch pulses together with buf_flush when fetch_pending is high in the popping cycle. It stays low on any flush without a pending fetch and on every plain dequeue.
- R8: A pc write replaces the top pc with pc_wr_value and suppresses the increment, whether or not retire is also asserted. Neither head_dequeue nor buf_flush pulses.
- R9: A retire or pc write on an empty stack raises err_underflow for one cycle and changes nothing.
- R10: active_lanes always equals the number of set bits in cur_mask.
- R11: A push request takes precedence: a retire or pc write in the same cycle is ignored. The pushed pc appears unmodified and no dequeue, flush or underflow pulse results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Push request from branch logic |
| push_pc | input | PC_W | pc of the pushed entry |
| push_rpc | input | PC_W | Reconvergence pc of the pushed entry |
| push_mask | input | LANES | Lane mask of the pushed entry |
| pc_wr_valid | input | 1 | Taken control flow: overwrite top pc |
| pc_wr_value | input | PC_W | New top pc |
| retire_valid | input | 1 | An instruction retired |
| fetch_pending | input | 1 | An instruction fetch is in flight |
| cur_pc | output | PC_W | Top entry pc (zero when empty) |
| cur_rpc | output | PC_W | Top entry reconvergence pc (zero when empty) |
| cur_mask | output | LANES | Top entry lane mask (zero when empty) |
| active_lanes | output | $clog2(LANES+1) | Set-bit count of cur_mask |
| buf_flush | output | 1 | Pulse: clear the instruction buffer |
| head_dequeue | output | 1 | Pulse: dequeue the head instruction |
| drop_fetch | output | 1 | Pulse: discard the pending fetch on return |
| err_overflow | output | 1 | Pulse: push refused, stack full |
| err_empty_push | output | 1 | Pulse: push refused, empty mask |
| err_underflow | output | 1 | Pulse: retire or pc write on empty stack |

## Verification
A corrupted entry or an off-by-one stack level does not show up when it happens. It shows up at the first pop that exposes the entry below: the wrong pc, reconvergence pc or mask appears on the cycle after that retire. The bench therefore fills the stack to its limit and unwinds it one level at a time, comparing each exposed entry.

A wrong comparison against the reconvergence pc shows up in the very next cycle. Either head_dequeue pulses where buf_flush should, or the reverse.

The mask sweep pushes every mask value the lanes allow and compares the lane count arithmetically.

// File: rtl/sds_pkg.sv
package sds_pkg;

    // Outcome of one cycle's request, resolved by priority.
    typedef enum logic [2:0] {
        OP_IDLE      = 3'd0,
        OP_PUSH      = 3'd1,
        OP_PUSH_ZERO = 3'd2,
        OP_PUSH_FULL = 3'd3,
        OP_PC_WRITE  = 3'd4,
        OP_ADVANCE   = 3'd5,
        OP_POP       = 3'd6,
        OP_UNDERFLOW = 3'd7
    } sds_op_e;

endpackage

// File: rtl/sds_op_decode.sv
module sds_op_decode
    import sds_pkg::*;
(
    input  logic    push_valid,
    input  logic    push_nonzero,
    input  logic    stack_full,
    input  logic    stack_empty,
    input  logic    pc_wr_valid,
    input  logic    retire_valid,
    input  logic    rpc_hit,
    output sds_op_e op
);

    always_comb begin
        op = OP_IDLE;
        if (push_valid) begin
            // a push request masks retire and pc write
            if (!push_nonzero)   op = OP_PUSH_ZERO;
            else if (stack_full) op = OP_PUSH_FULL;
            else                 op = OP_PUSH;
        end else if (pc_wr_valid || retire_valid) begin
            if (stack_empty)      op = OP_UNDERFLOW;
            else if (pc_wr_valid) op = OP_PC_WRITE;
            else if (rpc_hit)     op = OP_POP;
            else                  op = OP_ADVANCE;
        end
    end

endmodule

// File: rtl/sds_entry_store.sv
module sds_entry_store #(
    parameter int DEPTH = 4,
    parameter int W     = 40,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [W-1:0]     wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [W-1:0]     rd_data
);

    logic [W-1:0] slots_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slots_q[i] <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wr_idx == IDX_W'(i)) slots_q[i] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx == IDX_W'(i)) rd_data = slots_q[i];
        end
    end

endmodule

// File: rtl/sds_lane_count.sv
module sds_lane_count #(
    parameter int LANES = 8,
    parameter int CW    = 4
) (
    input  logic [LANES-1:0] mask,
    output logic [CW-1:0]    count
);

    logic [CW-1:0] part [LANES+1];

    assign part[0] = '0;

    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        assign part[gi+1] = part[gi] + CW'(mask[gi]);
    end

    assign count = part[LANES];

endmodule

// File: rtl/simt_divergence_stack.sv
module simt_divergence_stack
    import sds_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int LANES = 8,
    parameter int PC_W  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_valid,
    input  logic [PC_W-1:0]            push_pc,
    input  logic [PC_W-1:0]            push_rpc,
    input  logic [LANES-1:0]           push_mask,
    input  logic                       pc_wr_valid,
    input  logic [PC_W-1:0]            pc_wr_value,
    input  logic                       retire_valid,
    input  logic                       fetch_pending,
    output logic [PC_W-1:0]            cur_pc,
    output logic [PC_W-1:0]            cur_rpc,
    output logic [LANES-1:0]           cur_mask,
    output logic [$clog2(LANES+1)-1:0] active_lanes,
    output logic                       buf_flush,
    output logic                       head_dequeue,
    output logic                       drop_fetch,
    output logic                       err_overflow,
    output logic                       err_empty_push,
    output logic                       err_underflow
);

    localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W   = $clog2(DEPTH + 1);
    localparam int CW      = $clog2(LANES + 1);
    localparam int ENTRY_W = 2 * PC_W + LANES;

    typedef struct packed {
        logic [PC_W-1:0]  pc;
        logic [PC_W-1:0]  rpc;
        logic [LANES-1:0] mask;
    } entry_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flush;
        logic             deq;
        logic             drop;
        logic             ovf;
        logic             emp;
        logic             und;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    sds_op_e          op;
    logic [IDX_W-1:0] top_idx;
    logic             stack_empty, stack_full;
    entry_t           top_entry, shown;
    logic [PC_W-1:0]  next_pc;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    entry_t           wr_data;
    logic [ENTRY_W-1:0] rd_raw;

    assign stack_empty = (ctl_q.cnt == '0);
    assign stack_full  = (ctl_q.cnt == CNT_W'(DEPTH));
    assign top_idx     = IDX_W'(ctl_q.cnt - CNT_W'(1));
    assign top_entry   = entry_t'(rd_raw);
    assign next_pc     = top_entry.pc + PC_W'(1);

    sds_entry_store #(
        .DEPTH (DEPTH),
        .W     (ENTRY_W),
        .IDX_W (IDX_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (top_idx),
        .rd_data (rd_raw)
    );

    sds_op_decode u_decode (
        .push_valid   (push_valid),
        .push_nonzero (|push_mask),
        .stack_full   (stack_full),
        .stack_empty  (stack_empty),
        .pc_wr_valid  (pc_wr_valid),
        .retire_valid (retire_valid),
        .rpc_hit      (next_pc == top_entry.rpc),
        .op           (op)
    );

    // next-state process
    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.flush = 1'b0;
        ctl_d.deq   = 1'b0;
        ctl_d.drop  = 1'b0;
        ctl_d.ovf   = 1'b0;
        ctl_d.emp   = 1'b0;
        ctl_d.und   = 1'b0;
        wr_en       = 1'b0;
        wr_idx      = top_idx;
        wr_data     = top_entry;
        unique case (op)
            OP_PUSH: begin
                wr_en        = 1'b1;
                wr_idx       = ctl_q.cnt[IDX_W-1:0];
                wr_data.pc   = push_pc;
                wr_data.rpc  = push_rpc;
                wr_data.mask = push_mask;
                ctl_d.cnt    = ctl_q.cnt + CNT_W'(1);
            end
            OP_PUSH_ZERO: ctl_d.emp = 1'b1;
            OP_PUSH_FULL: ctl_d.ovf = 1'b1;
            OP_PC_WRITE: begin
                wr_en      = 1'b1;
                wr_data.pc = pc_wr_value;
            end
            OP_ADVANCE: begin
                wr_en      = 1'b1;
                wr_data.pc = next_pc;
                ctl_d.deq  = 1'b1;
            end
            OP_POP: begin
                ctl_d.cnt   = ctl_q.cnt - CNT_W'(1);
                ctl_d.flush = 1'b1;
                ctl_d.drop  = fetch_pending;
            end
            OP_UNDERFLOW: ctl_d.und = 1'b1;
            default: ;
        endcase
    end

    // register process
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign shown          = stack_empty ? entry_t'('0) : top_entry;
    assign cur_pc         = shown.pc;
    assign cur_rpc        = shown.rpc;
    assign cur_mask       = shown.mask;
    assign buf_flush      = ctl_q.flush;
    assign head_dequeue   = ctl_q.deq;
    assign drop_fetch     = ctl_q.drop;
    assign err_overflow   = ctl_q.ovf;
    assign err_empty_push = ctl_q.emp;
    assign err_underflow  = ctl_q.und;

    sds_lane_count #(
        .LANES (LANES),
        .CW    (CW)
    ) u_count (
        .mask  (cur_mask),
        .count (active_lanes)
    );

    AST_PUSH_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid && (|push_mask) && !stack_full
        |=> cur_pc == $past(push_pc) && cur_rpc == $past(push_rpc)
            && cur_mask == $past(push_mask)); // R2
    AST_PUSH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid && (push_mask == '0)
        |=> err_empty_push && $stable(ctl_q.cnt)); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid && (|push_mask) && stack_full
        |=> err_overflow && ctl_q.cnt == CNT_W'(DEPTH)); // R4
    AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        !push_valid && !pc_wr_valid && retire_valid && !stack_empty
            && (cur_pc + PC_W'(1) != cur_rpc)
        |=> head_dequeue && cur_pc == $past(cur_pc) + PC_W'(1)); // R5
    AST_POP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        buf_flush |-> ctl_q.cnt == $past(ctl_q.cnt) - CNT_W'(1)); // R6
    AST_DROP_WITH_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        drop_fetch |-> buf_flush); // R7
    AST_PC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !push_valid && pc_wr_valid && !stack_empty
        |=> cur_pc == $past(pc_wr_value) && !head_dequeue && !buf_flush); // R8
    AST_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !push_valid && (pc_wr_valid || retire_valid) && stack_empty
        |=> err_underflow && stack_empty); // R9
    AST_LANE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        active_lanes == CW'($countones(cur_mask))); // R10
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({buf_flush, head_dequeue, err_overflow, err_empty_push,
                  err_underflow})); // R11

endmodule

// File: tb/test_simt_divergence_stack.sv
module test_simt_divergence_stack;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_valid = 1'b0;
    logic [15:0] push_pc = '0;
    logic [15:0] push_rpc = '0;
    logic [7:0]  push_mask = '0;
    logic        pc_wr_valid = 1'b0;
    logic [15:0] pc_wr_value = '0;
    logic        retire_valid = 1'b0;
    logic        fetch_pending = 1'b0;
    logic [15:0] cur_pc, cur_rpc;
    logic [7:0]  cur_mask;
    logic [3:0]  active_lanes;
    logic        buf_flush, head_dequeue, drop_fetch;
    logic        err_overflow, err_empty_push, err_underflow;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    simt_divergence_stack #(.DEPTH(4), .LANES(8), .PC_W(16)) i_simt_divergence_stack (
        .clk(clk), .rst_n(rst_n),
        .push_valid(push_valid), .push_pc(push_pc), .push_rpc(push_rpc),
        .push_mask(push_mask), .pc_wr_valid(pc_wr_valid),
        .pc_wr_value(pc_wr_value), .retire_valid(retire_valid),
        .fetch_pending(fetch_pending), .cur_pc(cur_pc), .cur_rpc(cur_rpc),
        .cur_mask(cur_mask), .active_lanes(active_lanes),
        .buf_flush(buf_flush), .head_dequeue(head_dequeue),
        .drop_fetch(drop_fetch), .err_overflow(err_overflow),
        .err_empty_push(err_empty_push), .err_underflow(err_underflow)
    );

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual cycle %0d expected below 20000", cyc);
            finish_run();
        end
    end

    task automatic chk(input string req, input string what,
                       input longint got, input longint exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    function automatic int ones(input logic [7:0] m);
        int c = 0;
        for (int b = 0; b < 8; b++) c += m[b];
        return c;
    endfunction

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        push_valid = 1'b0; pc_wr_valid = 1'b0; retire_valid = 1'b0;
        fetch_pending = 1'b0; push_mask = '0;
    endtask

    task automatic do_push(input logic [15:0] p, input logic [15:0] r,
                           input logic [7:0] m);
        push_valid = 1'b1; push_pc = p; push_rpc = r; push_mask = m;
        step();
        idle();
    endtask

    task automatic do_retire(input logic pend);
        retire_valid = 1'b1; fetch_pending = pend;
        step();
        idle();
    endtask

    task automatic do_pcwr(input logic [15:0] v, input logic with_retire);
        pc_wr_valid = 1'b1; pc_wr_value = v; retire_valid = with_retire;
        step();
        idle();
    endtask

    task automatic chk_top(input string req, input logic [15:0] p,
                           input logic [15:0] r, input logic [7:0] m);
        chk(req, "cur_pc", cur_pc, p);
        chk(req, "cur_rpc", cur_rpc, r);
        chk(req, "cur_mask", cur_mask, m);
        chk("R10", "active_lanes", active_lanes, ones(m));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        // R1: reset state
        chk_top("R1", 16'h0, 16'h0, 8'h0);
        chk("R1", "pulses", {buf_flush, head_dequeue, drop_fetch, err_overflow,
                             err_empty_push, err_underflow}, 0);

        // R2 R3 R6 R7 R10: sweep every lane mask through push then pop
        for (int m = 0; m < 256; m++) begin
            do_push(16'h0100 + 16'(m), 16'h0101 + 16'(m), 8'(m));
            if (m == 0) begin
                chk("R3", "err_empty_push", err_empty_push, 1);
                chk_top("R3", 16'h0, 16'h0, 8'h0);
            end else begin
                chk("R2", "err_empty_push", err_empty_push, 0);
                chk_top("R2", 16'h0100 + 16'(m), 16'h0101 + 16'(m), 8'(m));
                do_retire(m[0]);
                chk("R6", "buf_flush", buf_flush, 1);
                chk("R6", "head_dequeue", head_dequeue, 0);
                chk("R7", "drop_fetch", drop_fetch, m[0]);
                chk_top("R1", 16'h0, 16'h0, 8'h0);
            end
        end

        // fill to depth
        do_push(16'h0020, 16'hFFFF, 8'hFF);
        do_push(16'h0030, 16'h0040, 8'h0F);
        do_push(16'h0050, 16'h0052, 8'h03);
        do_push(16'h0060, 16'h0061, 8'h01);
        chk_top("R2", 16'h0060, 16'h0061, 8'h01);
        do_push(16'h0070, 16'h0080, 8'h07);
        chk("R4", "err_overflow", err_overflow, 1);
        chk_top("R4", 16'h0060, 16'h0061, 8'h01);
        step();
        chk("R4", "err_overflow one cycle", err_overflow, 0);

        do_retire(1'b0);
        chk("R6", "buf_flush", buf_flush, 1);
        chk("R7", "drop_fetch no pending", drop_fetch, 0);
        chk_top("R6", 16'h0050, 16'h0052, 8'h03);

        do_retire(1'b1);
        chk("R5", "head_dequeue", head_dequeue, 1);
        chk("R5", "buf_flush", buf_flush, 0);
        chk("R7", "drop_fetch on dequeue", drop_fetch, 0);
        chk_top("R5", 16'h0051, 16'h0052, 8'h03);

        do_retire(1'b0);
        chk("R6", "buf_flush", buf_flush, 1);
        chk_top("R6", 16'h0030, 16'h0040, 8'h0F);

        do_pcwr(16'h003E, 1'b1);
        chk("R8", "cur_pc", cur_pc, 16'h003E);
        chk("R8", "no dequeue/flush", {head_dequeue, buf_flush}, 0);

        do_retire(1'b0);
        chk("R5", "cur_pc", cur_pc, 16'h003F);
        chk("R5", "head_dequeue", head_dequeue, 1);
        do_retire(1'b0);
        chk("R6", "buf_flush", buf_flush, 1);
        chk_top("R6", 16'h0020, 16'hFFFF, 8'hFF);

        do_pcwr(16'hFFFD, 1'b0);
        chk("R8", "cur_pc", cur_pc, 16'hFFFD);
        chk("R8", "no dequeue", head_dequeue, 0);
        do_retire(1'b0);
        chk("R5", "cur_pc", cur_pc, 16'hFFFE);
        do_retire(1'b0);
        chk("R6", "last pop flush", buf_flush, 1);
        chk_top("R1", 16'h0, 16'h0, 8'h0);

        do_retire(1'b0);
        chk("R9", "err_underflow retire", err_underflow, 1);
        chk_top("R9", 16'h0, 16'h0, 8'h0);
        do_pcwr(16'h1234, 1'b0);
        chk("R9", "err_underflow pc write", err_underflow, 1);
        chk("R9", "cur_pc", cur_pc, 16'h0);

        // R11: push wins over a same-cycle retire and pc write
        push_valid = 1'b1; push_pc = 16'h0100; push_rpc = 16'h0200;
        push_mask = 8'hAA; retire_valid = 1'b1; pc_wr_valid = 1'b1;
        pc_wr_value = 16'h0555;
        step();
        idle();
        chk_top("R11", 16'h0100, 16'h0200, 8'hAA);
        chk("R11", "no dequeue/flush/underflow",
            {head_dequeue, buf_flush, err_underflow}, 0);

        // R5 wrap
        do_pcwr(16'hFFFF, 1'b0);
        do_retire(1'b0);
        chk("R5", "wrapped cur_pc", cur_pc, 16'h0000);
        chk("R5", "head_dequeue", head_dequeue, 1);

        // R3 on a non-empty stack
        do_push(16'h0009, 16'h0009, 8'h00);
        chk("R3", "err_empty_push", err_empty_push, 1);
        chk_top("R3", 16'h0000, 16'h0200, 8'hAA);

        finish_run();
    end

endmodule